// File: doc/BRIEF.md
# Symmetric Divide-by-Three Clock Generator

This block turns a square-wave input clock into an output clock at one third of its frequency. The output is high for exactly three input half-periods and low for three. To get the half-period resolution, the state is split into two register groups. One group is clocked on the rising input edge and runs a three-state phase counter with a decoded term. The other group is clocked on the falling edge and holds a half-cycle-delayed copy of that term. The output is the OR of the two registered terms. No logic is inserted in the clock path.

The reset is synchronous and active low. Each register group clears on its own edge while reset is low. After reset is released, the output always starts at the same phase, so the divided clock can be aligned with other logic that shares the reset. A phase-marker output is high for one input cycle, starting at every rising edge of the divided clock. Output symmetry depends on the input duty cycle: any input high/low mismatch shows up directly as output asymmetry.

Top module: `tri_phase_divider`

## Requirements
- R1: The divided output repeats every six input half-periods (three input cycles). Successive rising edges of the output are exactly three input cycles apart.
- R2: Once running, every high interval of the divided output lasts three input half-periods, and every low interval lasts three input half-periods.
- R3: Each rising transition of the divided output follows a rising input edge. Each falling transition follows a falling input edge.
- R4: Number the input edges after reset release from 1, where the release happens just after a falling edge, so edge 1 is a rising edge. The output first goes high at edge 3 and first goes low at edge 6.
- R5: While reset is held low across at least one rising and one falling input edge, both the divided output and the phase marker are low.
- R6: The phase marker is high for exactly one input cycle, from the rising input edge at which the divided output rises to the next rising input edge. At all other times it is low.
- R7: If reset is asserted while the block is running and then released again, the output restarts with the same phase as in R4, whatever phase it had before.
- R8: The internal phase counter steps 0, 1, 2 and then back to 0 on rising input edges, and the output rise is decoded from phase 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, nominally 50% duty |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both edges |
| clk_div_out | output | 1 | Divided clock, one third of clk_in frequency |
| rise_mark | output | 1 | One-input-cycle pulse starting at each output rise |

## Verification
On every input edge, the bound checker checks the following: the counter wraps, the marker pulse lasts one cycle, the output agrees with the marker at both edge polarities, and both outputs are low during reset. These checks together tie the output level to the edge that produced it. The length of each high and low run, the exact edge index of the first rise after release, and the restart after a reset in mid-operation only become visible over a whole run. The bench's half-period reference model observes them in directed scenarios.

// File: rtl/tri_div_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the divide-by-three clock generator.
// Assumes the ratio stays at three; the counter width is derived from it.
package tri_div_pkg;
    localparam int unsigned DIV_RATIO  = 3;
    localparam int unsigned PHASE_W    = $clog2(DIV_RATIO);
    typedef logic [PHASE_W-1:0] phase_t;
    localparam phase_t FIRST_PHASE = phase_t'(0);
    localparam phase_t LAST_PHASE  = phase_t'(DIV_RATIO - 1);
    localparam phase_t RISE_PHASE  = phase_t'(1);
endpackage

// File: rtl/tri_div_rise_stage.sv
`timescale 1ns/1ps
// Rising-edge group: a modulo-RATIO phase counter and a registered term that
// is high for one input cycle per output period (decoded from RISE_PHASE).
// Assumes rst_n is synchronous to clk_in; clears on a rising edge with rst_n low.
module tri_div_rise_stage
    import tri_div_pkg::*;
#(
    parameter phase_t LAST = LAST_PHASE,
    parameter phase_t DECODE = RISE_PHASE
) (
    input  logic   clk_in,
    input  logic   rst_n,
    output phase_t phase_q,
    output logic   rise_term_q
);
    // Phase counter: advances on every rising edge and wraps after LAST.
    always_ff @(posedge clk_in) begin
        if (!rst_n)
            phase_q <= FIRST_PHASE;
        else if (phase_q == LAST)
            phase_q <= FIRST_PHASE;
        else
            phase_q <= phase_q + phase_t'(1);
    end

    // Decoded term: high for the cycle that follows the DECODE phase.
    always_ff @(posedge clk_in) begin
        if (!rst_n)
            rise_term_q <= 1'b0;
        else
            rise_term_q <= (phase_q == DECODE);
    end
endmodule

// File: rtl/tri_div_fall_stage.sv
`timescale 1ns/1ps
// Falling-edge group: copies the rising-edge term half an input cycle later.
// Assumes the input clock is close to 50% duty; clears on a falling edge with rst_n low.
module tri_div_fall_stage (
    input  logic clk_in,
    input  logic rst_n,
    input  logic rise_term,
    output logic fall_term_q
);
    // Half-cycle delayed copy of the rising-edge term.
    always_ff @(negedge clk_in) begin
        if (!rst_n)
            fall_term_q <= 1'b0;
        else
            fall_term_q <= rise_term;
    end
endmodule

// File: rtl/tri_div_merge.sv
`timescale 1ns/1ps
// Output merge: ORs registered terms only, so the output is glitch free.
// Assumes every input is a flop output; never drives a clock pin inside the block.
module tri_div_merge #(
    parameter int unsigned N_TERMS = 2
) (
    input  logic [N_TERMS-1:0] terms,
    output logic               merged
);
    // Wide OR of all registered terms.
    always_comb merged = |terms;
endmodule

// File: rtl/tri_phase_divider.sv
`timescale 1ns/1ps
// Divide-by-three clock with 50% duty: rising edges come from the rising-edge
// group, falling edges from the falling-edge group. Output is deterministic after
// a synchronous active-low reset. Duty accuracy follows the input duty cycle.
module tri_phase_divider
    import tri_div_pkg::*;
(
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_div_out,
    output logic rise_mark
);
    phase_t phase_w;
    logic   rise_term_w;
    logic   fall_term_w;

    tri_div_rise_stage #(
        .LAST   (LAST_PHASE),
        .DECODE (RISE_PHASE)
    ) u_rise (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .phase_q     (phase_w),
        .rise_term_q (rise_term_w)
    );

    tri_div_fall_stage u_fall (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .rise_term   (rise_term_w),
        .fall_term_q (fall_term_w)
    );

    tri_div_merge #(
        .N_TERMS (2)
    ) u_merge (
        .terms  ({fall_term_w, rise_term_w}),
        .merged (clk_div_out)
    );

    // Marker is the rising-edge term itself: one input cycle from each output rise.
    always_comb rise_mark = rise_term_w;
endmodule

// File: rtl/tri_phase_divider_chk.sv
`timescale 1ns/1ps
// Checker for tri_phase_divider, attached with bind below.
module tri_phase_divider_chk
    import tri_div_pkg::*;
(
    input logic   clk_in,
    input logic   rst_n,
    input logic   clk_div_out,
    input logic   rise_mark,
    input phase_t phase
);
    logic rst_low_prev = 1'b0;

    // Remembers whether reset was low at the previous falling edge.
    always_ff @(negedge clk_in) rst_low_prev <= !rst_n;

    // R8: counter wraps from its last phase to zero
    assert_phase_wrap_R8: assert property (@(posedge clk_in) disable iff (!rst_n)
        (phase == LAST_PHASE) |=> (phase == FIRST_PHASE));

    // R6: marker lasts a single input cycle
    assert_mark_one_cycle_R6: assert property (@(posedge clk_in) disable iff (!rst_n)
        rise_mark |=> !rise_mark);

    // R3: just before each rising edge the output equals the marker
    assert_out_at_rise_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        clk_div_out == rise_mark);

    // R2: output high during the marker cycle's falling edge
    assert_high_mid_R2: assert property (@(negedge clk_in) disable iff (!rst_n)
        rise_mark |-> clk_div_out);

    // R2: output still high at the falling edge after the marker ends
    assert_high_tail_R2: assert property (@(negedge clk_in) disable iff (!rst_n)
        $fell(rise_mark) |-> clk_div_out);

    // R5: marker cleared after a rising edge in reset
    assert_reset_mark_R5: assert property (@(posedge clk_in)
        !rst_n |=> !rise_mark);

    // R5: output low once reset has covered both edge polarities
    assert_reset_out_R5: assert property (@(negedge clk_in)
        (!rst_n && rst_low_prev) |-> !clk_div_out);
endmodule

bind tri_phase_divider tri_phase_divider_chk u_chk (
    .clk_in      (clk_in),
    .rst_n       (rst_n),
    .clk_div_out (clk_div_out),
    .rise_mark   (rise_mark),
    .phase       (phase_w)
);

// File: tb/tri_phase_divider_tb.sv
`timescale 1ns/1ps
module tri_phase_divider_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_div_out;
    logic rise_mark;
    int   checks = 0;
    int   failures = 0;

    always #4 clk = ~clk;

    tri_phase_divider u_dut (
        .clk_in      (clk),
        .rst_n       (rst_n),
        .clk_div_out (clk_div_out),
        .rise_mark   (rise_mark)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_out(input int e);
        return (e >= 3) && (((e - 3) % 6) < 3);
    endfunction

    function automatic bit model_mark(input int e);
        return (e >= 3) && (((e - 3) % 6) < 2);
    endfunction

    // Runs n half-periods after a release just past a falling edge; edge 1 is rising.
    task automatic run_model(input int n, input string tag);
        int run_len = 0;
        int changes = 0;
        int last_rise = -1;
        bit prev = 1'b0;
        for (int e = 1; e <= n; e++) begin
            @(clk);
            #2;
            check(clk_div_out == model_out(e), {tag, " R4 output level"}, clk_div_out, model_out(e));
            check(rise_mark == model_mark(e), {tag, " R6 marker level"}, rise_mark, model_mark(e));
            if (clk_div_out != prev) begin
                if (changes > 0)
                    check(run_len == 3, {tag, " R2 run length"}, run_len, 3);
                if (clk_div_out) begin
                    check(clk == 1'b1, {tag, " R3 rise on rising edge"}, clk, 1);
                    if (last_rise >= 0)
                        check(e - last_rise == 6, {tag, " R1 period"}, e - last_rise, 6);
                    last_rise = e;
                end else begin
                    check(clk == 1'b0, {tag, " R3 fall on falling edge"}, clk, 0);
                end
                changes++;
                run_len = 1;
            end else begin
                run_len++;
            end
            prev = clk_div_out;
        end
    endtask

    initial begin
        // R5: reset held over several edges
        repeat (3) @(posedge clk);
        #2;
        check(clk_div_out == 1'b0, "R5 out low in reset", clk_div_out, 0);
        check(rise_mark == 1'b0, "R5 mark low in reset", rise_mark, 0);
        @(negedge clk);
        #2;
        check(clk_div_out == 1'b0, "R5 out low after falling edge in reset", clk_div_out, 0);

        @(negedge clk);
        #1 rst_n = 1'b1;
        run_model(62, "first");

        // R7: reset in mid-operation at an arbitrary phase, then release again
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (4) @(posedge clk);
        #2;
        check(clk_div_out == 1'b0, "R7 R5 out low in mid reset", clk_div_out, 0);
        check(rise_mark == 1'b0, "R7 R5 mark low in mid reset", rise_mark, 0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        run_model(38, "R7 restart");

        // R7: second interruption while the output is high
        wait (clk_div_out == 1'b1);
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 rst_n = 1'b1;
        run_model(26, "R7 restart high");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule